// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns a single transfer request into one or two complete bus cycles on a bus that shares its lines between address and data. Each cycle walks through clock states T1, T2, T3, any number of wait states, and T4. In T1 it pulses the address latch strobe and puts the address on the shared lines. From T2 onward those lines either carry write data or are released so the addressed device can drive read data. The pads are not modelled: the shared lines appear as an output bus with an output-enable and a separate input bus.

The sequencer drives the active-low read and write strobes, the memory/IO select, the transmit/receive direction, a data enable, the two byte-lane controls (an active-low high-byte enable and address bit 0), and a 3-bit code naming the kind of cycle. The write strobe starts in T2. The read strobe waits until T3, so the address driven in T1 has a whole state to leave the lines first.

A slow device holds `ready` low to stretch the cycle. A 16-bit access at an odd address cannot go out as one transfer, so it is split into two byte cycles. The first uses the upper lane at the odd address. The second uses the lower lane at the next address.

Top module: `mux_bus_sequencer`

## Requirements
- R1: While `rst` is high and afterwards until a request is taken, the block is idle: `rd_n`=1, `wr_n`=1, `ale`=0, `den`=0, `bus_oe`=0, `status`=111, `done`=0 and `req_ready`=1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The next state is T1. In T1, `ale` is 1 for exactly one clock, `bus_oe`=1, `bus_out` equals the cycle address, and `den`=0.
- R3: Read cycle. In T2, `bus_oe`=0 and `rd_n`=1. `rd_n` is 0 in T3 and in every wait state, and returns to 1 in T4. `bus_in` is captured on the edge that leaves T3 or the last wait state.
- R4: Write cycle. `wr_n` is 0 from T2 through T3 and every wait state, and returns to 1 in T4. From T2 through T4, `bus_oe`=1 and `bus_out[15:0]` carries the write data. `rd_n` and `wr_n` are never low together.
- R5: `ready` is sampled on the edge that leaves T3 and on the edge that leaves each wait state. While it is 0, another wait state follows, with every strobe and code unchanged. Once it is 1, T4 follows.
- R6: {`bhe_n`,`a0`} is 00 for an aligned word, 01 for a byte at an odd address (upper lane, `bus_in[15:8]`), 10 for a byte at an even address (lower lane, `bus_in[7:0]`), and 11 when idle. A byte read returns its byte in `rdata[7:0]` with `rdata[15:8]`=0. A byte write replicates `req_wdata[7:0]` on both lanes.
- R7: A word at an odd address A runs two cycles. The first is at A with pair 01, writes `req_wdata[7:0]` and reads into `rdata[7:0]`. The second is at A+1 with pair 10, writes `req_wdata[15:8]` and reads into `rdata[15:8]`. `done` pulses only in the final T4.
- R8: `status` during T1, T2, T3 and wait states: 001 I/O read, 010 I/O write, 100 code fetch (memory read with `req_code`=1), 101 memory read, 110 memory write. It is 111 in T4 and while idle.
- R9: From T1 through T4, `mem_io` is 1 for memory and 0 for I/O, and `dt_r` is 1 for a write and 0 for a read.
- R10: `den` is 1 in T2, T3, wait states and T4, and 0 in T1 and idle, so it never overlaps `ale`.
- R11: If `rst` is held for four clocks in the middle of a cycle, the block returns to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_code | input | 1 | Memory read is an instruction fetch |
| req_word | input | 1 | 1 word transfer, 0 byte transfer |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| done | output | 1 | Final T4 of the transfer |
| rdata | output | 16 | Assembled read data |
| ready | input | 1 | Device ready; low inserts wait states |
| bus_in | input | 16 | Data read from the shared lines |
| bus_out | output | AW | Value driven on the shared lines |
| bus_oe | output | 1 | Shared lines driven |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mem_io | output | 1 | 1 memory, 0 I/O |
| dt_r | output | 1 | 1 transmit, 0 receive |
| den | output | 1 | Data phase enable |
| bhe_n | output | 1 | High-byte lane enable, active low |
| a0 | output | 1 | Address bit 0 of the current cycle |
| status | output | 3 | Cycle-type code |

## Verification
The hardest case to reach is the second half of a split word access while wait states are being inserted. The bench has to hold `ready` low across T3 of one half and then check that the second half restarts at T1 with the incremented address, the other lane and `done` still low until the final T4. Directed tasks place `ready` on the negative edge before each sampling edge, counted per state. They also present different `bus_in` values in each half, so a lane or byte swap shows up in `rdata`. A reset pulse is driven during the data phase of a write to check recovery in the middle of a cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  // {bhe_n, a0}
  typedef enum logic [1:0] {
    LN_WORD = 2'b00,
    LN_HIGH = 2'b01,
    LN_LOW  = 2'b10,
    LN_NONE = 2'b11
  } lane_t;

  localparam logic [2:0] ST_IO_RD   = 3'b001;
  localparam logic [2:0] ST_IO_WR   = 3'b010;
  localparam logic [2:0] ST_CODE    = 3'b100;
  localparam logic [2:0] ST_MEM_RD  = 3'b101;
  localparam logic [2:0] ST_MEM_WR  = 3'b110;
  localparam logic [2:0] ST_PASSIVE = 3'b111;

  function automatic logic [2:0] cycle_status(input logic wr, input logic mem, input logic code);
    if (!mem) return wr ? ST_IO_WR : ST_IO_RD;
    if (wr) return ST_MEM_WR;
    if (code) return ST_CODE;
    return ST_MEM_RD;
  endfunction

  function automatic logic [DATA_W-1:0] dup_byte(input logic [LANE_W-1:0] b);
    return {b, b};
  endfunction
endpackage

// File: rtl/mbs_lane_plan.sv
module mbs_lane_plan
  import mbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0]     base_addr,
  input  logic              is_word,
  input  logic              second_part,
  input  logic [DATA_W-1:0] wdata,
  output logic [AW-1:0]     cyc_addr,
  output lane_t             lane,
  output logic              is_split,
  output logic [DATA_W-1:0] wr_bus
);
  always_comb begin
    is_split = is_word & base_addr[0];
    cyc_addr = base_addr;
    lane     = LN_LOW;
    wr_bus   = dup_byte(wdata[LANE_W-1:0]);
    if (is_split && second_part) begin
      cyc_addr = base_addr + AW'(1);
      lane     = LN_LOW;
      wr_bus   = dup_byte(wdata[DATA_W-1:LANE_W]);
    end else if (is_split) begin
      lane     = LN_HIGH;
    end else if (is_word) begin
      lane     = LN_WORD;
      wr_bus   = wdata;
    end else if (base_addr[0]) begin
      lane     = LN_HIGH;
    end
  end
endmodule

// File: rtl/mbs_phase_ctl.sv
module mbs_phase_ctl
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   ready,
  input  logic   split,
  output phase_t phase,
  output logic   part,
  output logic   last_part
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      part  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_T1;
          part  <= 1'b0;
        end
        PH_T1:   phase <= PH_T2;
        PH_T2:   phase <= PH_T3;
        PH_T3:   phase <= ready ? PH_T4 : PH_TW;
        PH_TW:   phase <= ready ? PH_T4 : PH_TW;
        PH_T4: begin
          if (split && !part) begin
            phase <= PH_T1;
            part  <= 1'b1;
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign last_part = !split || part;

  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TW) |-> $past(!ready)); // R5
  AST_T4_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T4) |-> $past(ready)); // R5
  AST_SECOND_HALF: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_T4 && phase == PH_T1) |-> part); // R7
endmodule

// File: rtl/mbs_strobe_dec.sv
module mbs_strobe_dec
  import mbs_pkg::*;
(
  input  phase_t phase,
  input  logic   wr,
  output logic   ale,
  output logic   rd_n,
  output logic   wr_n,
  output logic   den,
  output logic   drive_addr,
  output logic   drive_data,
  output logic   active,
  output logic   code_phase
);
  logic data_ph, strobe_ph;
  always_comb begin
    data_ph    = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
    strobe_ph  = (phase == PH_T3) || (phase == PH_TW);
    ale        = (phase == PH_T1);
    drive_addr = (phase == PH_T1);
    den        = data_ph;
    rd_n       = !(!wr && strobe_ph);
    wr_n       = !(wr && (strobe_ph || phase == PH_T2));
    drive_data = wr && data_ph;
    active     = (phase != PH_IDLE);
    code_phase = active && (phase != PH_T4);
  end
endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import mbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_code,
  input  logic              req_word,
  input  logic [AW-1:0]     req_addr,
  input  logic [15:0]       req_wdata,
  output logic              done,
  output logic [15:0]       rdata,
  input  logic              ready,
  input  logic [15:0]       bus_in,
  output logic [AW-1:0]     bus_out,
  output logic              bus_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mem_io,
  output logic              dt_r,
  output logic              den,
  output logic              bhe_n,
  output logic              a0,
  output logic [2:0]        status
);
  localparam int PAD_W = AW - DATA_W;

  logic              r_write, r_mem, r_code, r_word;
  logic [AW-1:0]     r_addr;
  logic [DATA_W-1:0] r_wdata;

  phase_t        phase;
  logic          part, last_part, start, capture;
  logic [AW-1:0] cyc_addr;
  lane_t         lane;
  logic          is_split;
  logic [DATA_W-1:0] wr_bus;
  logic          drive_addr, drive_data, active, code_phase;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_write <= 1'b0;
      r_mem   <= 1'b0;
      r_code  <= 1'b0;
      r_word  <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
    end else if (start) begin
      r_write <= req_write;
      r_mem   <= req_mem;
      r_code  <= req_code;
      r_word  <= req_word;
      r_addr  <= req_addr;
      r_wdata <= req_wdata;
    end
  end

  mbs_lane_plan #(.AW(AW)) u_lane (
    .base_addr  (r_addr),
    .is_word    (r_word),
    .second_part(part),
    .wdata      (r_wdata),
    .cyc_addr   (cyc_addr),
    .lane       (lane),
    .is_split   (is_split),
    .wr_bus     (wr_bus)
  );

  mbs_phase_ctl u_phase (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ready    (ready),
    .split    (is_split),
    .phase    (phase),
    .part     (part),
    .last_part(last_part)
  );

  mbs_strobe_dec u_strobe (
    .phase     (phase),
    .wr        (r_write),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den       (den),
    .drive_addr(drive_addr),
    .drive_data(drive_data),
    .active    (active),
    .code_phase(code_phase)
  );

  // read data capture on the edge leaving T3 or the last wait state
  assign capture = !r_write && ready && (phase == PH_T3 || phase == PH_TW);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (capture) begin
      unique case (lane)
        LN_WORD: rdata <= bus_in;
        LN_HIGH: if (is_split) rdata[LANE_W-1:0] <= bus_in[DATA_W-1:LANE_W];
                 else rdata <= {{LANE_W{1'b0}}, bus_in[DATA_W-1:LANE_W]};
        LN_LOW:  if (is_split) rdata[DATA_W-1:LANE_W] <= bus_in[LANE_W-1:0];
                 else rdata <= {{LANE_W{1'b0}}, bus_in[LANE_W-1:0]};
        default: rdata <= rdata;
      endcase
    end
  end

  always_comb begin
    if (drive_addr)      bus_out = cyc_addr;
    else if (drive_data) bus_out = {{PAD_W{1'b0}}, wr_bus};
    else                 bus_out = '0;
  end

  assign bus_oe        = drive_addr || drive_data;
  assign mem_io        = active ? r_mem : 1'b0;
  assign dt_r          = active ? r_write : 1'b0;
  assign {bhe_n, a0}   = active ? lane : LN_NONE;
  assign status        = code_phase ? cycle_status(r_write, r_mem, r_code) : ST_PASSIVE;
  assign done          = (phase == PH_T4) && last_part;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (rd_n && wr_n && !bus_oe && !den && status == ST_PASSIVE)); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R2
  AST_READ_FLOATS: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R4
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (rst)
    (active && {bhe_n, a0} == 2'b00) |-> !bus_out[0] || !ale); // R6
  AST_HIGH_ODD: assert property (@(posedge clk) disable iff (rst)
    (ale && {bhe_n, a0} == 2'b01) |-> bus_out[0]); // R6
  AST_DONE_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    done |-> (status == ST_PASSIVE && rd_n && wr_n)); // R8
  AST_DEN_NOT_ALE: assert property (@(posedge clk) disable iff (rst)
    ale |-> !den); // R10
endmodule

// File: tb/mux_bus_sequencer_bench.sv
module mux_bus_sequencer_bench;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_code = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ready = 1'b1;
  logic [15:0] bus_in = '0;
  logic req_ready, done, bus_oe, ale, rd_n, wr_n, mem_io, dt_r, den, bhe_n, a0;
  logic [15:0] rdata;
  logic [AW-1:0] bus_out;
  logic [2:0] status;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mux_bus_sequencer #(.AW(AW)) u_mux_bus_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mem(req_mem), .req_code(req_code), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .ready(ready), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mem_io(mem_io), .dt_r(dt_r), .den(den),
    .bhe_n(bhe_n), .a0(a0), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input bit wr, input bit mem, input bit code);
    logic [2:0] c;
    c = mem ? (wr ? 3'b110 : (code ? 3'b100 : 3'b101)) : (wr ? 3'b010 : 3'b001);
    return c;
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R1 rd_n"}, rd_n, 1);
    chk({tag, " R1 wr_n"}, wr_n, 1);
    chk({tag, " R1 ale"}, ale, 0);
    chk({tag, " R1 den"}, den, 0);
    chk({tag, " R1 bus_oe"}, bus_oe, 0);
    chk({tag, " R8 idle status"}, status, 3'b111);
    chk({tag, " R1 req_ready"}, req_ready, 1);
    chk({tag, " R1 done"}, done, 0);
    chk({tag, " R6 idle pair"}, {bhe_n, a0}, 2'b11);
  endtask

  task automatic run_xfer(input bit wr, input bit mem, input bit code, input bit word,
                          input logic [AW-1:0] addr, input logic [15:0] wdata,
                          input int nwait, input logic [15:0] d1, input logic [15:0] d2,
                          input logic [15:0] exp_rd);
    bit split;
    int parts;
    logic [2:0] st;
    split = word && addr[0];
    parts = split ? 2 : 1;
    st = exp_code(wr, mem, code);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mem = mem; req_code = code;
    req_word = word; req_addr = addr; req_wdata = wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int p = 0; p < parts; p++) begin
      logic [AW-1:0] a;
      logic [1:0] pair;
      logic [15:0] wb;
      if (split) begin
        a    = (p == 0) ? addr : addr + AW'(1);
        pair = (p == 0) ? 2'b01 : 2'b10;
        wb   = (p == 0) ? {wdata[7:0], wdata[7:0]} : {wdata[15:8], wdata[15:8]};
      end else if (word) begin
        a = addr; pair = 2'b00; wb = wdata;
      end else begin
        a = addr; pair = addr[0] ? 2'b01 : 2'b10; wb = {wdata[7:0], wdata[7:0]};
      end
      bus_in = (p == 0) ? d1 : d2;
      // T1
      chk("R2 T1 ale", ale, 1);
      chk("R2 T1 bus_oe", bus_oe, 1);
      chk("R2 T1 address", bus_out, a);
      chk("R10 T1 den", den, 0);
      chk("R8 T1 status", status, st);
      chk("R9 T1 mem_io", mem_io, mem);
      chk("R9 T1 dt_r", dt_r, wr);
      chk("R6 R7 T1 pair", {bhe_n, a0}, pair);
      chk("R3 R4 T1 strobes", {rd_n, wr_n}, 2'b11);
      // T2
      @(negedge clk);
      chk("R2 T2 ale", ale, 0);
      chk("R10 T2 den", den, 1);
      chk("R8 T2 status", status, st);
      if (wr) begin
        chk("R4 T2 bus_oe", bus_oe, 1);
        chk("R4 T2 data", bus_out[15:0], wb);
        chk("R4 T2 wr_n", wr_n, 0);
      end else begin
        chk("R3 T2 float", bus_oe, 0);
        chk("R3 T2 rd_n", rd_n, 1);
      end
      // T3
      @(negedge clk);
      chk("R8 T3 status", status, st);
      chk("R9 T3 mem_io", mem_io, mem);
      if (wr) chk("R4 T3 wr_n", wr_n, 0);
      else    chk("R3 T3 rd_n", rd_n, 0);
      ready = (nwait == 0);
      for (int w = 0; w < nwait; w++) begin
        @(negedge clk);
        chk("R5 wait status", status, st);
        chk("R5 wait ale", ale, 0);
        chk("R5 wait strobes", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
        chk("R5 wait den", den, 1);
        if (wr) chk("R5 wait data", bus_out[15:0], wb);
        ready = (w == nwait - 1);
      end
      // T4
      @(negedge clk);
      ready = 1'b1;
      chk("R3 R4 T4 strobes", {rd_n, wr_n}, 2'b11);
      chk("R8 T4 passive", status, 3'b111);
      chk("R10 T4 den", den, 1);
      chk("R9 T4 dt_r", dt_r, wr);
      chk("R6 T4 pair", {bhe_n, a0}, pair);
      chk("R7 done", done, (p == parts - 1) ? 1 : 0);
      if (wr) chk("R4 T4 data", bus_out[15:0], wb);
      @(negedge clk);
    end
    check_idle("after");
    if (!wr) chk("R3 R6 R7 rdata", rdata, exp_rd);
  endtask

  task automatic test_reset_state;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_idle("reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("post-reset");
  endtask

  task automatic test_word_read;   // R3 R6
    run_xfer(0, 1, 0, 1, 20'h12344, 16'h0, 0, 16'hA55A, 16'h0, 16'hA55A);
  endtask

  task automatic test_byte_reads;  // R6
    run_xfer(0, 1, 0, 0, 20'h00100, 16'h0, 0, 16'h3C7E, 16'h0, 16'h007E);
    run_xfer(0, 1, 0, 0, 20'h00101, 16'h0, 0, 16'h3C7E, 16'h0, 16'h003C);
  endtask

  task automatic test_split_read;  // R7 R5
    run_xfer(0, 1, 0, 1, 20'h00203, 16'h0, 2, 16'hBB11, 16'h22CC, 16'hCCBB);
  endtask

  task automatic test_word_write_wait; // R4 R5
    run_xfer(1, 1, 0, 1, 20'h40000, 16'hBEEF, 2, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic test_split_io_write;  // R7 R9
    run_xfer(1, 0, 0, 1, 20'h00011, 16'h1234, 1, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic test_code_and_io;     // R8
    run_xfer(0, 1, 1, 1, 20'hFFFF0, 16'h0, 3, 16'h90E8, 16'h0, 16'h90E8);
    run_xfer(0, 0, 0, 0, 20'h00060, 16'h0, 0, 16'h5511, 16'h0, 16'h0011);
    run_xfer(1, 0, 0, 0, 20'h00061, 16'h00A7, 0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic test_mid_reset;       // R11
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_mem = 1'b1; req_code = 1'b0;
    req_word = 1'b1; req_addr = 20'h00500; req_wdata = 16'h7777;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 reached data phase", wr_n, 0);
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_idle("R11 mid reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R11 released");
  endtask

  initial begin
    test_reset_state();
    test_word_read();
    test_byte_reads();
    test_split_read();
    test_word_write_wait();
    test_split_io_write();
    test_code_and_io();
    test_mid_reset();
    test_word_read();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule